// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the horizontal and vertical scan timing for a raster display from a pixel clock. It runs a pixel counter and a line counter. From those counters and a set of programmed boundary positions it drives horizontal sync, vertical sync, a blanking signal and an active-video enable. It also presents the current pixel and line coordinates. Every boundary is written as an absolute counter value measured from the start of sync, not as a porch length. On each axis the positions are, in order: end of sync, start of active video, end of active video, and the period total.

Software writes through a simple write strobe, address and data port. A small sequencer has two states. ST_IDLE holds both counters at zero and keeps the display blanked. ST_RUN scans the raster. The sequencer takes the IDLE-to-RUN transition when the run bit is set, and the RUN-to-IDLE transition when the run bit is cleared. Written timing values are staged. They are copied into the working set only while the sequencer is idle or at the last pixel of a frame, so a frame never mixes two configurations.

A programmable event line sets a sticky status flag when the scan reaches it. That flag, gated by an interrupt enable, forms the interrupt output.

Top module: `raster_timing_gen`

## Requirements
- R1: While running, horizontal sync is active for pixel x below the sync-end position. Data enable needs act_start <= x < act_end on the horizontal axis.
- R2: The vertical axis follows the same rule with line y: vertical sync is active for y below its sync-end position, and data enable also needs v act_start <= y < v act_end.
- R3: Reset leaves the generator running with an 800-clock line, a 525-line frame, sync ends at 96 and 2, active windows [144,784) and [35,515), and the event line at 515. Both syncs and blank are active high and the interrupt is masked.
- R4: While running, the pixel counter steps by one each clock. After total-1 it returns to 0 and the line counter steps, and the line counter returns to 0 after its own total-1.
- R5: Timing written while running takes effect from the first pixel of the next frame. Until then the current frame keeps its old geometry.
- R6: A staged set whose active width is below 16 or above 2048 on either axis is not taken. The previous working set stays in force.
- R7: Control register (address 9) bits select output levels. Bit 1 set makes hsync active high, bit 2 does the same for vsync, and bit 3 makes blank high during blanking. Each cleared bit inverts its output.
- R8: Clearing control bit 0 (run) stops the scan. Both counters return to 0, syncs sit at their inactive level, data enable is low and blank is asserted.
- R9: The status flag sets one clock after the scan enters pixel 0 of the event line (address 8) and stays set.
- R10: Writing address 10 with data bit 0 set clears the status flag. With bit 0 clear the write has no effect, and a set in the same clock wins.
- R11: The interrupt output equals the status flag ANDed with control bit 4.
- R12: Register addresses: 0..3 hold horizontal sync end, active start, active end and total. 4..7 hold the same for vertical. 8 is the event line, 9 is control, 10 is status clear. Writes land on the clock edge of the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register address |
| wr_data_i | input | 13 | Register write data |
| hsync_o | output | 1 | Horizontal sync, polarity per control bit 1 |
| vsync_o | output | 1 | Vertical sync, polarity per control bit 2 |
| blank_o | output | 1 | Blanking, polarity per control bit 3 |
| de_o | output | 1 | Active-video enable, active high |
| pix_x_o | output | 13 | Current pixel counter |
| line_y_o | output | 13 | Current line counter |
| irq_o | output | 1 | Vertical event interrupt |

## Verification
Syncs, blank and data enable are combinational from the counters. The bench therefore locates a position by watching the coordinate ports at the falling edge and checks those outputs in that same half cycle. A register write lands on the rising edge inside the write task. Polarity and interrupt-mask changes are checked at the falling edge where the task returns. The status flag is checked as still clear at the event position and set one falling edge later. After the run bit is cleared, the sequencer needs one edge to go idle and the counters one more to clear, so the idle checks come two falling edges after the write. Staged geometry is judged only by positions the scan reaches in later frames, such as a line that runs past the old total.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
    localparam int unsigned DTG_CW = 13;
    localparam int unsigned DTG_AW = 4;
    localparam int unsigned CTL_W  = 5;

    localparam logic [DTG_AW-1:0] REG_H_SYNC_END  = 4'd0;
    localparam logic [DTG_AW-1:0] REG_H_ACT_START = 4'd1;
    localparam logic [DTG_AW-1:0] REG_H_ACT_END   = 4'd2;
    localparam logic [DTG_AW-1:0] REG_H_TOTAL     = 4'd3;
    localparam logic [DTG_AW-1:0] REG_V_SYNC_END  = 4'd4;
    localparam logic [DTG_AW-1:0] REG_V_ACT_START = 4'd5;
    localparam logic [DTG_AW-1:0] REG_V_ACT_END   = 4'd6;
    localparam logic [DTG_AW-1:0] REG_V_TOTAL     = 4'd7;
    localparam logic [DTG_AW-1:0] REG_EVT_LINE    = 4'd8;
    localparam logic [DTG_AW-1:0] REG_CTRL        = 4'd9;
    localparam logic [DTG_AW-1:0] REG_STAT_CLR    = 4'd10;

    localparam int unsigned CTL_RUN    = 0;
    localparam int unsigned CTL_HS_HI  = 1;
    localparam int unsigned CTL_VS_HI  = 2;
    localparam int unsigned CTL_BL_HI  = 3;
    localparam int unsigned CTL_IRQ_EN = 4;

    typedef logic [DTG_CW-1:0] pos_t;

    typedef struct packed {
        pos_t sync_end;
        pos_t act_start;
        pos_t act_end;
        pos_t total;
    } axis_t;

    typedef struct packed {
        axis_t h;
        axis_t v;
        pos_t  evt_line;
    } tcfg_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_e;
endpackage

// File: rtl/dtg_regs.sv
module dtg_regs
    import dtg_pkg::*;
#(
    parameter tcfg_t             RST_CFG = '0,
    parameter logic [CTL_W-1:0]  RST_CTL = '0
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [DTG_AW-1:0] wr_addr_i,
    input  pos_t              wr_data_i,
    input  logic              evt_set_i,
    output tcfg_t             staged_o,
    output logic [CTL_W-1:0]  ctl_o,
    output logic              status_o,
    output logic              clr_req_o
);
    tcfg_t             staged_q;
    logic [CTL_W-1:0]  ctl_q;
    logic              status_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            staged_q <= RST_CFG;
            ctl_q    <= RST_CTL;
        end else if (wr_en_i) begin
            case (wr_addr_i)
                REG_H_SYNC_END:  staged_q.h.sync_end  <= wr_data_i;
                REG_H_ACT_START: staged_q.h.act_start <= wr_data_i;
                REG_H_ACT_END:   staged_q.h.act_end   <= wr_data_i;
                REG_H_TOTAL:     staged_q.h.total     <= wr_data_i;
                REG_V_SYNC_END:  staged_q.v.sync_end  <= wr_data_i;
                REG_V_ACT_START: staged_q.v.act_start <= wr_data_i;
                REG_V_ACT_END:   staged_q.v.act_end   <= wr_data_i;
                REG_V_TOTAL:     staged_q.v.total     <= wr_data_i;
                REG_EVT_LINE:    staged_q.evt_line    <= wr_data_i;
                REG_CTRL:        ctl_q                <= wr_data_i[CTL_W-1:0];
                default: ;
            endcase
        end
    end

    // Clear request: write-one to the status address
    always_comb begin
        clr_req_o = wr_en_i && (wr_addr_i == REG_STAT_CLR) && wr_data_i[0];
    end

    // Sticky flag, set has priority over clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            status_q <= 1'b0;
        end else if (evt_set_i) begin
            status_q <= 1'b1;
        end else if (clr_req_o) begin
            status_q <= 1'b0;
        end
    end

    assign staged_o = staged_q;
    assign ctl_o    = ctl_q;
    assign status_o = status_q;
endmodule

// File: rtl/dtg_counter.sv
module dtg_counter #(
    parameter int unsigned W = 13
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         clear_i,
    input  logic         step_i,
    input  logic [W-1:0] last_i,
    output logic [W-1:0] cnt_o,
    output logic         at_last_o
);
    logic [W-1:0] cnt_q;

    always_comb begin
        at_last_o = (cnt_q == last_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (clear_i) begin
            cnt_q <= '0;
        end else if (step_i) begin
            cnt_q <= at_last_o ? '0 : cnt_q + W'(1);
        end
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/dtg_seq.sv
module dtg_seq
    import dtg_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic enable_i,
    output logic run_o
);
    seq_state_e state_q;
    seq_state_e state_d;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (enable_i)  state_d = ST_RUN;
            ST_RUN:  if (!enable_i) state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        run_o = (state_q == ST_RUN);
    end
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
    import dtg_pkg::*;
#(
    parameter int unsigned DEF_H_SYNC = 96,
    parameter int unsigned DEF_H_BP   = 48,
    parameter int unsigned DEF_H_ACT  = 640,
    parameter int unsigned DEF_H_FP   = 16,
    parameter int unsigned DEF_V_SYNC = 2,
    parameter int unsigned DEF_V_BP   = 33,
    parameter int unsigned DEF_V_ACT  = 480,
    parameter int unsigned DEF_V_FP   = 10,
    parameter int unsigned MIN_ACT    = 16,
    parameter int unsigned MAX_ACT    = 2048
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 wr_en_i,
    input  logic [DTG_AW-1:0]    wr_addr_i,
    input  logic [DTG_CW-1:0]    wr_data_i,
    output logic                 hsync_o,
    output logic                 vsync_o,
    output logic                 blank_o,
    output logic                 de_o,
    output logic [DTG_CW-1:0]    pix_x_o,
    output logic [DTG_CW-1:0]    line_y_o,
    output logic                 irq_o
);
    localparam int unsigned DW = DTG_CW + 1;

    localparam pos_t D_HSE = pos_t'(DEF_H_SYNC);
    localparam pos_t D_HAS = pos_t'(DEF_H_SYNC + DEF_H_BP);
    localparam pos_t D_HAE = pos_t'(DEF_H_SYNC + DEF_H_BP + DEF_H_ACT);
    localparam pos_t D_HT  = pos_t'(DEF_H_SYNC + DEF_H_BP + DEF_H_ACT + DEF_H_FP);
    localparam pos_t D_VSE = pos_t'(DEF_V_SYNC);
    localparam pos_t D_VAS = pos_t'(DEF_V_SYNC + DEF_V_BP);
    localparam pos_t D_VAE = pos_t'(DEF_V_SYNC + DEF_V_BP + DEF_V_ACT);
    localparam pos_t D_VT  = pos_t'(DEF_V_SYNC + DEF_V_BP + DEF_V_ACT + DEF_V_FP);

    localparam tcfg_t DEF_CFG = '{
        h:        '{sync_end: D_HSE, act_start: D_HAS, act_end: D_HAE, total: D_HT},
        v:        '{sync_end: D_VSE, act_start: D_VAS, act_end: D_VAE, total: D_VT},
        evt_line: D_VAE
    };

    localparam logic [CTL_W-1:0] DEF_CTL =
        CTL_W'((1 << CTL_RUN) | (1 << CTL_HS_HI) | (1 << CTL_VS_HI) | (1 << CTL_BL_HI));

    function automatic logic span_ok(input pos_t s, input pos_t e);
        logic [DW-1:0] d;
        d = {1'b0, e} - {1'b0, s};
        return (e > s) && (d >= DW'(MIN_ACT)) && (d <= DW'(MAX_ACT));
    endfunction

    tcfg_t            staged;
    tcfg_t            act_q;
    logic [CTL_W-1:0] ctl_q;
    logic             status;
    logic             clr_req;
    logic             run;
    pos_t             h_cnt, v_cnt;
    pos_t             h_last, v_last;
    logic             h_at_last, v_at_last;
    logic             frame_end;
    logic             staged_ok;
    logic             evt_hit;
    logic             hs_act, vs_act, blank_act;
    logic             irq_en;

    dtg_regs #(
        .RST_CFG (DEF_CFG),
        .RST_CTL (DEF_CTL)
    ) u_regs (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .evt_set_i (evt_hit),
        .staged_o  (staged),
        .ctl_o     (ctl_q),
        .status_o  (status),
        .clr_req_o (clr_req)
    );

    dtg_seq u_seq (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .enable_i (ctl_q[CTL_RUN]),
        .run_o    (run)
    );

    always_comb begin
        h_last = act_q.h.total - pos_t'(1);
        v_last = act_q.v.total - pos_t'(1);
    end

    dtg_counter #(.W(DTG_CW)) u_hcnt (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .clear_i   (!run),
        .step_i    (run),
        .last_i    (h_last),
        .cnt_o     (h_cnt),
        .at_last_o (h_at_last)
    );

    dtg_counter #(.W(DTG_CW)) u_vcnt (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .clear_i   (!run),
        .step_i    (run && h_at_last),
        .last_i    (v_last),
        .cnt_o     (v_cnt),
        .at_last_o (v_at_last)
    );

    always_comb begin
        frame_end = run && h_at_last && v_at_last;
        staged_ok = span_ok(staged.h.act_start, staged.h.act_end) &&
                    span_ok(staged.v.act_start, staged.v.act_end);
    end

    // Working set: refreshed only while idle or on the last pixel of a frame
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            act_q <= DEF_CFG;
        end else if ((!run || frame_end) && staged_ok) begin
            act_q <= staged;
        end
    end

    always_comb begin
        hs_act    = run && (h_cnt < act_q.h.sync_end);
        vs_act    = run && (v_cnt < act_q.v.sync_end);
        de_o      = run &&
                    (h_cnt >= act_q.h.act_start) && (h_cnt < act_q.h.act_end) &&
                    (v_cnt >= act_q.v.act_start) && (v_cnt < act_q.v.act_end);
        blank_act = !de_o;
        evt_hit   = run && (h_cnt == '0) && (v_cnt == act_q.evt_line);
        irq_en    = ctl_q[CTL_IRQ_EN];
    end

    always_comb begin
        hsync_o  = ctl_q[CTL_HS_HI] ? hs_act    : !hs_act;
        vsync_o  = ctl_q[CTL_VS_HI] ? vs_act    : !vs_act;
        blank_o  = ctl_q[CTL_BL_HI] ? blank_act : !blank_act;
        irq_o    = status && irq_en;
        pix_x_o  = h_cnt;
        line_y_o = v_cnt;
    end
endmodule

// File: rtl/dtg_checker.sv
module dtg_checker
    import dtg_pkg::*;
(
    input logic  clk_i,
    input logic  rst_ni,
    input logic  run_i,
    input pos_t  pix_i,
    input pos_t  line_i,
    input pos_t  h_last_i,
    input logic  de_i,
    input logic  irq_i,
    input logic  irq_en_i,
    input logic  status_i,
    input logic  clr_req_i,
    input logic  evt_hit_i,
    input logic  frame_end_i,
    input tcfg_t act_i
);
    assert_pix_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_i && (pix_i != h_last_i)) |=> (pix_i == $past(pix_i) + pos_t'(1)));

    assert_idle_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_i |=> ((pix_i == '0) && (line_i == '0)));

    assert_idle_no_de_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_i |-> !de_i);

    assert_frame_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_i && !frame_end_i) |=> $stable(act_i));

    assert_evt_sets_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        evt_hit_i |=> status_i);

    assert_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (status_i && clr_req_i && !evt_hit_i) |=> !status_i);

    assert_irq_gate_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_i |-> (irq_en_i && status_i));
endmodule

bind raster_timing_gen dtg_checker u_dtg_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (run),
    .pix_i       (h_cnt),
    .line_i      (v_cnt),
    .h_last_i    (h_last),
    .de_i        (de_o),
    .irq_i       (irq_o),
    .irq_en_i    (irq_en),
    .status_i    (status),
    .clr_req_i   (clr_req),
    .evt_hit_i   (evt_hit),
    .frame_end_i (frame_end),
    .act_i       (act_q)
);

// File: tb/raster_timing_gen_tb.sv
module raster_timing_gen_tb_top;
    import dtg_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    pos_t       wr_data = '0;
    logic       hsync, vsync, blank, de, irq;
    pos_t       pix, line;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    raster_timing_gen dut_i (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .hsync_o   (hsync),
        .vsync_o   (vsync),
        .blank_o   (blank),
        .de_o      (de),
        .pix_x_o   (pix),
        .line_y_o  (line),
        .irq_o     (irq)
    );

    // Probe table for the small raster: x, y, hsync, vsync, de
    // h: sync_end 4, active [6,22), total 24; v: sync_end 1, active [2,18), total 19
    localparam int PROBE [12][5] = '{
        '{0, 0, 1, 1, 0}, '{3, 0, 1, 1, 0}, '{4, 0, 0, 1, 0}, '{0, 1, 1, 0, 0},
        '{10, 1, 0, 0, 0}, '{5, 2, 0, 0, 0}, '{6, 2, 0, 0, 1}, '{21, 2, 0, 0, 1},
        '{22, 2, 0, 0, 0}, '{21, 17, 0, 0, 1}, '{6, 18, 0, 0, 0}, '{23, 18, 0, 0, 0}
    };

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input int d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = pos_t'(d);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic wait_xy(input string req, input int x, input int y);
        bit found = 1'b0;
        for (int i = 0; i < 40000; i++) begin
            @(negedge clk);
            if (int'(pix) == x && int'(line) == y) begin
                found = 1'b1;
                break;
            end
        end
        check_eq(req, $sformatf("reach (%0d,%0d)", x, y), int'(found), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        // Reset state (R3, R8)
        repeat (3) @(negedge clk);
        check_eq("R8", "reset hsync", int'(hsync), 0);
        check_eq("R8", "reset vsync", int'(vsync), 0);
        check_eq("R8", "reset blank", int'(blank), 1);
        check_eq("R8", "reset de", int'(de), 0);
        check_eq("R3", "reset pix", int'(pix), 0);
        check_eq("R3", "reset irq", int'(irq), 0);
        rst_n = 1'b1;

        // Reset defaults (R3)
        wait_xy("R3", 95, 0);
        check_eq("R3", "hsync x95", int'(hsync), 1);
        check_eq("R3", "vsync y0", int'(vsync), 1);
        wait_xy("R3", 96, 0);
        check_eq("R3", "hsync x96", int'(hsync), 0);
        wait_xy("R3", 799, 0);
        @(negedge clk);
        check_eq("R4", "wrap pix at 800", int'(pix), 0);
        check_eq("R4", "line step at 800", int'(line), 1);
        wait_xy("R3", 0, 2);
        check_eq("R3", "vsync y2", int'(vsync), 0);
        wait_xy("R3", 144, 34);
        check_eq("R3", "de y34", int'(de), 0);
        wait_xy("R3", 143, 35);
        check_eq("R3", "de x143", int'(de), 0);
        wait_xy("R3", 144, 35);
        check_eq("R3", "de x144", int'(de), 1);
        check_eq("R3", "blank x144", int'(blank), 0);
        wait_xy("R3", 783, 35);
        check_eq("R3", "de x783", int'(de), 1);
        wait_xy("R3", 784, 35);
        check_eq("R3", "de x784", int'(de), 0);

        // Stop (R8)
        wr(4'd9, 5'b01110);
        repeat (2) @(negedge clk);
        check_eq("R8", "idle pix", int'(pix), 0);
        check_eq("R8", "idle line", int'(line), 0);
        check_eq("R8", "idle hsync", int'(hsync), 0);
        check_eq("R8", "idle vsync", int'(vsync), 0);
        check_eq("R8", "idle blank", int'(blank), 1);
        check_eq("R8", "idle de", int'(de), 0);

        // Small raster through the register map (R12)
        wr(4'd0, 4);  wr(4'd1, 6);  wr(4'd2, 22); wr(4'd3, 24);
        wr(4'd4, 1);  wr(4'd5, 2);  wr(4'd6, 18); wr(4'd7, 19);
        wr(4'd8, 5);
        wr(4'd9, 5'b11111);

        for (int k = 0; k < 12; k++) begin
            wait_xy("R12", PROBE[k][0], PROBE[k][1]);
            check_eq("R1", $sformatf("hsync probe %0d", k), int'(hsync), PROBE[k][2]);
            check_eq("R2", $sformatf("vsync probe %0d", k), int'(vsync), PROBE[k][3]);
            check_eq("R1 R2", $sformatf("de probe %0d", k), int'(de), PROBE[k][4]);
            check_eq("R7", $sformatf("blank probe %0d", k), int'(blank), 1 - PROBE[k][4]);
        end
        @(negedge clk);
        check_eq("R4", "frame wrap pix", int'(pix), 0);
        check_eq("R4", "frame wrap line", int'(line), 0);
        wait_xy("R4", 23, 4);
        @(negedge clk);
        check_eq("R4", "line wrap pix", int'(pix), 0);
        check_eq("R4", "line wrap line", int'(line), 5);

        // Event flag, clear and mask (R9, R10, R11)
        wait_xy("R10", 0, 8);
        wr(4'd10, 1);
        check_eq("R10", "irq after clear", int'(irq), 0);
        wait_xy("R9", 0, 5);
        check_eq("R9", "irq at event entry", int'(irq), 0);
        @(negedge clk);
        check_eq("R9", "irq one clock later", int'(irq), 1);
        wait_xy("R9", 0, 9);
        check_eq("R9", "irq sticky", int'(irq), 1);
        wr(4'd9, 5'b01111);
        check_eq("R11", "irq masked", int'(irq), 0);
        wr(4'd9, 5'b11111);
        check_eq("R11", "irq unmasked", int'(irq), 1);
        wr(4'd10, 0);
        check_eq("R10", "write zero keeps flag", int'(irq), 1);
        wr(4'd10, 1);
        check_eq("R10", "write one clears", int'(irq), 0);

        // Polarity (R7)
        wr(4'd9, 5'b10001);
        wait_xy("R7", 2, 3);
        check_eq("R7", "hsync low-active in sync", int'(hsync), 0);
        check_eq("R7", "vsync low-active idle", int'(vsync), 1);
        check_eq("R7", "blank low-active blanking", int'(blank), 0);
        wait_xy("R7", 10, 3);
        check_eq("R7", "hsync low-active idle", int'(hsync), 1);
        check_eq("R7", "blank low-active visible", int'(blank), 1);
        wait_xy("R7", 5, 0);
        check_eq("R7", "vsync low-active in sync", int'(vsync), 0);
        wr(4'd9, 5'b11111);

        // Frame-boundary update (R5)
        wait_xy("R5", 0, 3);
        wr(4'd3, 26);
        wait_xy("R5", 23, 6);
        @(negedge clk);
        check_eq("R5", "old total in frame", int'(pix), 0);
        wait_xy("R5", 25, 1);
        @(negedge clk);
        check_eq("R5", "new total wrap", int'(line), 2);

        // Rejected geometry (R6)
        wait_xy("R6", 0, 3);
        wr(4'd2, 14);
        wait_xy("R6", 0, 1);
        wait_xy("R6", 20, 3);
        check_eq("R6", "narrow set rejected", int'(de), 1);
        wr(4'd2, 2055);
        wait_xy("R6", 0, 1);
        wait_xy("R6", 21, 3);
        check_eq("R6", "wide set rejected", int'(de), 1);
        wr(4'd2, 22);
        wr(4'd6, 10);
        wait_xy("R6", 0, 1);
        wait_xy("R6", 10, 12);
        check_eq("R6", "short vertical rejected", int'(de), 1);
        wr(4'd6, 18);

        // Stop again (R8)
        wr(4'd9, 5'b11110);
        repeat (2) @(negedge clk);
        check_eq("R8", "stop pix", int'(pix), 0);
        check_eq("R8", "stop blank", int'(blank), 1);
        check_eq("R8", "stop hsync", int'(hsync), 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule